// File: doc/BRIEF.md
# Floating-Point Environment Save/Restore Sequencer

This block moves the floating-point unit's environment image between the unit's live state and memory, one word-wide beat at a time. A caller picks one of three commands: store the environment, full save, or load the environment. Two mode inputs pick one of four image layouts. The operand size selects a 14-byte or a 28-byte image. Real or protected mode decides which pointer fields are written and how wide they are. The live control word, status word, tag word, stack top and the instruction and operand pointers are captured when the command starts.

A full save first writes the environment image. It then writes the eight 80-bit stack registers, fetched through a register read port, as ten-byte images placed directly after the environment. Finally it sends the reset state of the unit over the update port. A load reads the control, status and tag words back and sends them over the same update port, with the stack top taken from the loaded status word.

Every beat is held on the memory port until the memory accepts it with a ready signal. A one-cycle done pulse marks the end of each command.

Top module: `fenv_seq`

## Requirements
- R1: With cmd 0 (store environment), size32=0 and prot_mode=0, exactly five 16-bit write beats occur, in this order: control word at base+0, status at +2, tag at +4, instruction offset bits 15:0 at +6, operand offset bits 15:0 at +10. Bytes +8 and +12 are not written.
- R2: With size32=0 and prot_mode=1, a store writes seven 16-bit beats. The first five are as in R1. In addition, the instruction segment goes to +8 and the operand segment to +12.
- R3: With size32=1 and prot_mode=0, a store writes six beats. Five are 16-bit: control at +0, status at +4, tag at +8, instruction offset bits 15:0 at +12, operand offset bits 15:0 at +20. The sixth is a 32-bit beat at +24 carrying operand offset bits 31:16 shifted left by 12.
- R4: With size32=1 and prot_mode=1, a store writes seven beats. Control, status and tag are 16-bit beats at +0, +4 and +8. Four 32-bit beats follow: instruction offset at +12, zero-extended instruction segment at +16, operand offset at +20, zero-extended operand segment at +24.
- R5: The stored status word equals the captured status word with bits 13:11 replaced by the captured stack top.
- R6: With cmd 1 (full save), the environment beats are followed by three beats for each register k = 0..7, with reg_sel=k. The beats are bits 31:0 (32-bit) at base+L+10k, bits 63:32 (32-bit) at +4, and bits 79:64 (16-bit) at +8. L is 14 for size32=0 and 28 for size32=1. Nothing is written past base+L+80.
- R7: At the end of a full save, upd_valid pulses with upd_cw=16'h037F, upd_sw=0, upd_tw=16'hFFFF (all tags empty) and upd_top=0.
- R8: With cmd 2 (load environment), exactly three 16-bit read beats occur. They fetch the control, status and tag words from +0/+2/+4 (size32=0) or +0/+4/+8 (size32=1). upd_valid then pulses with those three words, and upd_top equals bits 13:11 of the loaded status word.
- R9: While mem_req is high and mem_ready low, mem_req, mem_addr, mem_wdata and mem_we hold their values.
- R10: busy is high from the cycle after an accepted start until done. done is high for exactly one cycle, the cycle after the last accepted beat. mem_req is low whenever busy is low.
- R11: start is ignored while busy, and start with cmd 3 is ignored in any state.
- R12: A plain environment store completes with done but no upd_valid pulse. upd_valid occurs only together with done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start request, sampled while idle |
| cmd | input | 2 | 0 store environment, 1 full save, 2 load environment, 3 none |
| size32 | input | 1 | 1 selects the 28-byte layout |
| prot_mode | input | 1 | 1 selects the protected-mode layout |
| base_addr | input | AW | Byte address of the image |
| cw_in | input | 16 | Live control word |
| sw_in | input | 16 | Live status word |
| tw_in | input | 16 | Live tag word |
| top_in | input | 3 | Live stack top |
| ip_off_in | input | 32 | Instruction pointer offset |
| ip_seg_in | input | 16 | Instruction pointer segment |
| op_off_in | input | 32 | Operand pointer offset |
| op_seg_in | input | 16 | Operand pointer segment |
| reg_sel | output | RIW | Stack register index for the read port |
| reg_img | input | 80 | Stack register contents for reg_sel |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_wide | output | 1 | 1 four-byte beat, 0 two-byte beat |
| mem_addr | output | AW | Beat byte address |
| mem_wdata | output | 32 | Write data, little-endian |
| mem_rdata | input | 32 | Read data, bits 15:0 used |
| mem_ready | input | 1 | Beat accepted this cycle |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| upd_valid | output | 1 | Apply the update values to the unit |
| upd_cw | output | 16 | New control word |
| upd_sw | output | 16 | New status word |
| upd_tw | output | 16 | New tag word |
| upd_top | output | 3 | New stack top |

## Verification
The hardest case to reach from the ports is a start request that arrives while a long full save is in the middle of its register beats. If that request were taken, it would corrupt the captured mode halfway through the image. The stimulus slows the memory with wait states and issues a conflicting load command partway through the register phase. It then confirms that the beat count, the final image and the single update pulse all belong to the original full save. Wait states also stretch every beat, so that address and data must be held across several cycles.

// File: rtl/fenv_pkg.sv
package fenv_pkg;

  typedef enum logic [1:0] {
    CMD_STENV    = 2'd0,
    CMD_FULLSAVE = 2'd1,
    CMD_LDENV    = 2'd2,
    CMD_NONE     = 2'd3
  } cmd_e;

  typedef enum logic [2:0] {
    FLD_CW, FLD_SW, FLD_TW, FLD_IPO, FLD_IPS, FLD_OPO, FLD_OPS, FLD_OPHI
  } fld_e;

  typedef struct packed {
    logic       last;
    fld_e       fld;
    logic [4:0] off;
    logic       wide;
  } beat_t;

  localparam int          REG_BITS  = 80;
  localparam int          REG_BYTES = 10;
  localparam logic [15:0] CW_INIT   = 16'h037F;
  localparam logic [15:0] TW_EMPTY  = 16'hFFFF;

  function automatic beat_t mk(input fld_e f, input logic [4:0] o,
                               input logic w, input logic l);
    beat_t b;
    b.fld  = f;
    b.off  = o;
    b.wide = w;
    b.last = l;
    return b;
  endfunction

  // Environment image length in bytes for the selected operand size.
  function automatic logic [4:0] img_len(input logic sz32);
    return sz32 ? 5'd28 : 5'd14;
  endfunction

  // Status word as stored: stack top placed in bits 13:11.
  function automatic logic [15:0] sw_with_top(input logic [15:0] sw,
                                              input logic [2:0] top);
    return {sw[15:14], top, sw[10:0]};
  endfunction

  // Beat number idx of an environment transfer.
  function automatic beat_t env_beat(input logic sz32, input logic prot,
                                     input logic load, input logic [2:0] idx);
    beat_t b;
    b = mk(FLD_CW, 5'd0, 1'b0, 1'b1);
    if (load) begin
      b.fld  = (idx == 3'd0) ? FLD_CW : (idx == 3'd1) ? FLD_SW : FLD_TW;
      b.off  = sz32 ? {idx, 2'b00} : {1'b0, idx, 1'b0};
      b.last = (idx >= 3'd2);
    end else begin
      case ({sz32, prot})
        2'b00: case (idx)
          3'd0:    b = mk(FLD_CW,  5'd0,  1'b0, 1'b0);
          3'd1:    b = mk(FLD_SW,  5'd2,  1'b0, 1'b0);
          3'd2:    b = mk(FLD_TW,  5'd4,  1'b0, 1'b0);
          3'd3:    b = mk(FLD_IPO, 5'd6,  1'b0, 1'b0);
          default: b = mk(FLD_OPO, 5'd10, 1'b0, 1'b1);
        endcase
        2'b01: case (idx)
          3'd0:    b = mk(FLD_CW,  5'd0,  1'b0, 1'b0);
          3'd1:    b = mk(FLD_SW,  5'd2,  1'b0, 1'b0);
          3'd2:    b = mk(FLD_TW,  5'd4,  1'b0, 1'b0);
          3'd3:    b = mk(FLD_IPO, 5'd6,  1'b0, 1'b0);
          3'd4:    b = mk(FLD_IPS, 5'd8,  1'b0, 1'b0);
          3'd5:    b = mk(FLD_OPO, 5'd10, 1'b0, 1'b0);
          default: b = mk(FLD_OPS, 5'd12, 1'b0, 1'b1);
        endcase
        2'b10: case (idx)
          3'd0:    b = mk(FLD_CW,   5'd0,  1'b0, 1'b0);
          3'd1:    b = mk(FLD_SW,   5'd4,  1'b0, 1'b0);
          3'd2:    b = mk(FLD_TW,   5'd8,  1'b0, 1'b0);
          3'd3:    b = mk(FLD_IPO,  5'd12, 1'b0, 1'b0);
          3'd4:    b = mk(FLD_OPO,  5'd20, 1'b0, 1'b0);
          default: b = mk(FLD_OPHI, 5'd24, 1'b1, 1'b1);
        endcase
        default: case (idx)
          3'd0:    b = mk(FLD_CW,  5'd0,  1'b0, 1'b0);
          3'd1:    b = mk(FLD_SW,  5'd4,  1'b0, 1'b0);
          3'd2:    b = mk(FLD_TW,  5'd8,  1'b0, 1'b0);
          3'd3:    b = mk(FLD_IPO, 5'd12, 1'b1, 1'b0);
          3'd4:    b = mk(FLD_IPS, 5'd16, 1'b1, 1'b0);
          3'd5:    b = mk(FLD_OPO, 5'd20, 1'b1, 1'b0);
          default: b = mk(FLD_OPS, 5'd24, 1'b1, 1'b1);
        endcase
      endcase
    end
    return b;
  endfunction

endpackage

// File: rtl/fenv_layout.sv
module fenv_layout
  import fenv_pkg::*;
(
  input  logic       sz32,
  input  logic       prot,
  input  logic       load,
  input  logic [2:0] idx,
  output beat_t      beat,
  output logic [4:0] env_bytes
);
  always_comb begin
    beat      = env_beat(sz32, prot, load, idx);
    env_bytes = img_len(sz32);
  end
endmodule

// File: rtl/fenv_regimg.sv
module fenv_regimg
  import fenv_pkg::*;
(
  input  logic [REG_BITS-1:0] img,
  input  logic [1:0]          part,
  output logic [31:0]         data,
  output logic [3:0]          off,
  output logic                wide,
  output logic                last_part
);
  always_comb begin
    case (part)
      2'd0:    begin data = img[31:0];            off = 4'd0; wide = 1'b1; end
      2'd1:    begin data = img[63:32];           off = 4'd4; wide = 1'b1; end
      default: begin data = {16'h0, img[79:64]};  off = 4'd8; wide = 1'b0; end
    endcase
    last_part = (part == 2'd2);
  end
endmodule

// File: rtl/fenv_seq.sv
module fenv_seq
  import fenv_pkg::*;
#(
  parameter int AW   = 16,
  parameter int NREG = 8,
  localparam int RIW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [1:0]          cmd,
  input  logic                size32,
  input  logic                prot_mode,
  input  logic [AW-1:0]       base_addr,
  input  logic [15:0]         cw_in,
  input  logic [15:0]         sw_in,
  input  logic [15:0]         tw_in,
  input  logic [2:0]          top_in,
  input  logic [31:0]         ip_off_in,
  input  logic [15:0]         ip_seg_in,
  input  logic [31:0]         op_off_in,
  input  logic [15:0]         op_seg_in,
  output logic [RIW-1:0]      reg_sel,
  input  logic [REG_BITS-1:0] reg_img,
  output logic                mem_req,
  output logic                mem_we,
  output logic                mem_wide,
  output logic [AW-1:0]       mem_addr,
  output logic [31:0]         mem_wdata,
  input  logic [31:0]         mem_rdata,
  input  logic                mem_ready,
  output logic                busy,
  output logic                done,
  output logic                upd_valid,
  output logic [15:0]         upd_cw,
  output logic [15:0]         upd_sw,
  output logic [15:0]         upd_tw,
  output logic [2:0]          upd_top
);

  typedef enum logic [1:0] {S_IDLE, S_ENV, S_REG, S_FIN} st_e;

  st_e             state;
  cmd_e            cmd_q;
  logic            sz_q, prot_q;
  logic [AW-1:0]   base_q, reg_base_q;
  logic [15:0]     cw_q, sw_q, tw_q, ips_q, ops_q;
  logic [31:0]     ipo_q, opo_q;
  logic [2:0]      idx_q;
  logic [RIW-1:0]  ri_q;
  logic [1:0]      part_q;
  logic [15:0]     rd_cw, rd_sw, rd_tw;

  // Named internal events
  logic  start_ok, beat_fire, is_load, env_done, reg_done;
  beat_t eb;
  logic [4:0]  env_bytes;
  logic [31:0] rg_data, env_data;
  logic [3:0]  rg_off;
  logic        rg_wide, rg_last;

  assign is_load  = (cmd_q == CMD_LDENV);
  assign start_ok = (state == S_IDLE) && start && (cmd_e'(cmd) != CMD_NONE);
  assign beat_fire = mem_req && mem_ready;
  assign env_done = (state == S_ENV) && beat_fire && eb.last;
  assign reg_done = (state == S_REG) && beat_fire && rg_last &&
                    (ri_q == RIW'(NREG - 1));

  fenv_layout u_layout (
    .sz32(sz_q), .prot(prot_q), .load(is_load), .idx(idx_q),
    .beat(eb), .env_bytes(env_bytes)
  );

  fenv_regimg u_regimg (
    .img(reg_img), .part(part_q), .data(rg_data), .off(rg_off),
    .wide(rg_wide), .last_part(rg_last)
  );

  always_comb begin
    case (eb.fld)
      FLD_CW:   env_data = {16'h0, cw_q};
      FLD_SW:   env_data = {16'h0, sw_q};
      FLD_TW:   env_data = {16'h0, tw_q};
      FLD_IPO:  env_data = eb.wide ? ipo_q : {16'h0, ipo_q[15:0]};
      FLD_IPS:  env_data = {16'h0, ips_q};
      FLD_OPO:  env_data = eb.wide ? opo_q : {16'h0, opo_q[15:0]};
      FLD_OPS:  env_data = {16'h0, ops_q};
      default:  env_data = {4'h0, opo_q[31:16], 12'h0};
    endcase
  end

  always_comb begin
    busy      = (state != S_IDLE);
    done      = (state == S_FIN);
    mem_req   = (state == S_ENV) || (state == S_REG);
    mem_we    = !is_load;
    reg_sel   = ri_q;
    if (state == S_REG) begin
      mem_wide  = rg_wide;
      mem_addr  = reg_base_q + AW'(rg_off);
      mem_wdata = rg_data;
    end else begin
      mem_wide  = eb.wide;
      mem_addr  = base_q + AW'(eb.off);
      mem_wdata = env_data;
    end
    upd_valid = done && (cmd_q != CMD_STENV);
    if (cmd_q == CMD_FULLSAVE) begin
      upd_cw  = CW_INIT;
      upd_sw  = 16'h0;
      upd_tw  = TW_EMPTY;
      upd_top = 3'd0;
    end else begin
      upd_cw  = rd_cw;
      upd_sw  = rd_sw;
      upd_tw  = rd_tw;
      upd_top = rd_sw[13:11];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cmd_q      <= CMD_STENV;
      sz_q       <= 1'b0;
      prot_q     <= 1'b0;
      base_q     <= '0;
      reg_base_q <= '0;
      cw_q       <= '0;
      sw_q       <= '0;
      tw_q       <= '0;
      ips_q      <= '0;
      ops_q      <= '0;
      ipo_q      <= '0;
      opo_q      <= '0;
      idx_q      <= '0;
      ri_q       <= '0;
      part_q     <= '0;
      rd_cw      <= '0;
      rd_sw      <= '0;
      rd_tw      <= '0;
    end else begin
      case (state)
        S_IDLE: if (start_ok) begin
          state  <= S_ENV;
          cmd_q  <= cmd_e'(cmd);
          sz_q   <= size32;
          prot_q <= prot_mode;
          base_q <= base_addr;
          cw_q   <= cw_in;
          sw_q   <= sw_with_top(sw_in, top_in);
          tw_q   <= tw_in;
          ipo_q  <= ip_off_in;
          ips_q  <= ip_seg_in;
          opo_q  <= op_off_in;
          ops_q  <= op_seg_in;
          idx_q  <= '0;
        end
        S_ENV: if (beat_fire) begin
          if (is_load) begin
            case (eb.fld)
              FLD_CW:  rd_cw <= mem_rdata[15:0];
              FLD_SW:  rd_sw <= mem_rdata[15:0];
              default: rd_tw <= mem_rdata[15:0];
            endcase
          end
          if (eb.last) begin
            if (cmd_q == CMD_FULLSAVE) begin
              state      <= S_REG;
              ri_q       <= '0;
              part_q     <= '0;
              reg_base_q <= base_q + AW'(env_bytes);
            end else begin
              state <= S_FIN;
            end
          end else begin
            idx_q <= idx_q + 3'd1;
          end
        end
        S_REG: if (beat_fire) begin
          if (rg_last) begin
            part_q     <= '0;
            reg_base_q <= reg_base_q + AW'(REG_BYTES);
            if (ri_q == RIW'(NREG - 1)) state <= S_FIN;
            else                        ri_q  <= ri_q + RIW'(1);
          end else begin
            part_q <= part_q + 2'd1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // Assertions
  p_hold_beat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) &&
                              $stable(mem_wdata) && $stable(mem_we));

  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

  p_done_after_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (env_done && cmd_q != CMD_FULLSAVE) || reg_done |=> done);

  p_mode_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) && busy |-> $stable(cmd_q) && $stable(sz_q) && $stable(base_q));

  p_reinit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid && cmd_q == CMD_FULLSAVE |->
      upd_cw == CW_INIT && upd_sw == 16'h0 && upd_tw == TW_EMPTY && upd_top == 3'd0);

  p_direction_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_we == (cmd_q != CMD_LDENV));

  p_upd_with_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> done && cmd_q != CMD_STENV);

endmodule

// File: tb/sim_fenv_seq.sv
`timescale 1ns/1ps
module sim_fenv_seq;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        start = 1'b0;
  logic [1:0]  cmd = 2'd0;
  logic        size32 = 1'b0, prot_mode = 1'b0;
  logic [AW-1:0] base_addr = 16'h0040;
  logic [15:0] cw_in = 16'h0A7F, sw_in = 16'h38C1, tw_in = 16'h5AA5;
  logic [2:0]  top_in = 3'd2;
  logic [31:0] ip_off_in = 32'hDEADBEEF, op_off_in = 32'h98765432;
  logic [15:0] ip_seg_in = 16'h1B2C, op_seg_in = 16'h4D5E;
  logic [2:0]  reg_sel;
  logic [79:0] reg_img;
  logic        mem_req, mem_we, mem_wide, mem_ready;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic        busy, done, upd_valid;
  logic [15:0] upd_cw, upd_sw, upd_tw;
  logic [2:0]  upd_top;

  fenv_seq #(.AW(AW), .NREG(8)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .size32(size32),
    .prot_mode(prot_mode), .base_addr(base_addr), .cw_in(cw_in), .sw_in(sw_in),
    .tw_in(tw_in), .top_in(top_in), .ip_off_in(ip_off_in), .ip_seg_in(ip_seg_in),
    .op_off_in(op_off_in), .op_seg_in(op_seg_in), .reg_sel(reg_sel),
    .reg_img(reg_img), .mem_req(mem_req), .mem_we(mem_we), .mem_wide(mem_wide),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready), .busy(busy), .done(done), .upd_valid(upd_valid),
    .upd_cw(upd_cw), .upd_sw(upd_sw), .upd_tw(upd_tw), .upd_top(upd_top)
  );

  function automatic logic [79:0] regval(input int i);
    logic [7:0] b;
    b = i[7:0];
    return {8'h5A, b, 64'h0123456789ABCDEF ^ {8{b}}};
  endfunction
  assign reg_img = regval(int'(reg_sel));

  // Memory model and monitors (negedge)
  logic [7:0] mem [0:255];
  int lat = 0, wcnt = 0;
  int beats = 0, writes = 0, done_cnt = 0, upd_cnt = 0, hold_err = 0;
  logic in_wait = 1'b0;
  logic [AW-1:0] last_addr = '0;
  logic [31:0] last_wd = '0;
  logic [15:0] cap_cw = '0, cap_sw = '0, cap_tw = '0;
  logic [2:0]  cap_top = '0;
  int nchecks = 0, nfails = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ready <= 1'b0;
      mem_rdata <= '0;
      wcnt = 0;
      in_wait = 1'b0;
    end else begin
      if (done) done_cnt++;
      if (upd_valid) begin
        upd_cnt++;
        cap_cw = upd_cw; cap_sw = upd_sw; cap_tw = upd_tw; cap_top = upd_top;
      end
      if (mem_ready) begin
        mem_ready <= 1'b0;
        in_wait = 1'b0;
      end else if (mem_req) begin
        if (in_wait && (mem_addr != last_addr || mem_wdata != last_wd)) hold_err++;
        last_addr = mem_addr;
        last_wd   = mem_wdata;
        if (wcnt >= lat) begin
          mem_ready <= 1'b1;
          wcnt = 0;
          beats++;
          in_wait = 1'b0;
          if (mem_we) begin
            writes++;
            mem[mem_addr[7:0]]        = mem_wdata[7:0];
            mem[mem_addr[7:0] + 8'd1] = mem_wdata[15:8];
            if (mem_wide) begin
              mem[mem_addr[7:0] + 8'd2] = mem_wdata[23:16];
              mem[mem_addr[7:0] + 8'd3] = mem_wdata[31:24];
            end
          end else begin
            mem_rdata <= {mem[mem_addr[7:0] + 8'd3], mem[mem_addr[7:0] + 8'd2],
                          mem[mem_addr[7:0] + 8'd1], mem[mem_addr[7:0]]};
          end
        end else begin
          wcnt++;
          in_wait = 1'b1;
        end
      end
    end
  end

  task automatic chk(input logic ok, input string req, input logic [79:0] act,
                     input logic [79:0] exp);
    nchecks++;
    if (!ok) begin
      nfails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] rd16(input int a);
    return {mem[a+1], mem[a]};
  endfunction
  function automatic logic [31:0] rd32(input int a);
    return {mem[a+3], mem[a+2], mem[a+1], mem[a]};
  endfunction

  task automatic fill();
    for (int i = 0; i < 256; i++) mem[i] = 8'hEE;
  endtask

  task automatic go(input logic [1:0] c, input logic s32, input logic pm);
    @(negedge clk);
    cmd = c; size32 = s32; prot_mode = pm; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    int d0;
    d0 = done_cnt;
    for (int i = 0; i < 3000 && done_cnt == d0; i++) @(negedge clk);
  endtask

  function automatic logic [15:0] exp_sw();
    return (sw_in & 16'hC7FF) | (16'(top_in) << 11);
  endfunction

  task automatic t_reset();
    chk(busy == 0 && done == 0 && mem_req == 0 && upd_valid == 0, "R10 reset state",
        {busy, done, mem_req, upd_valid}, 0);
  endtask

  task automatic t_store_16real();
    int b; b = 'h40;
    fill(); beats = 0; lat = 0;
    go(2'd0, 1'b0, 1'b0);
    chk(busy == 1, "R10 busy after start", busy, 1);
    wait_done();
    chk(beats == 5, "R1 beat count", beats, 5);
    chk(rd16(b) == cw_in && rd16(b+4) == tw_in, "R1 control/tag", {rd16(b), rd16(b+4)}, {cw_in, tw_in});
    chk(rd16(b+2) == exp_sw(), "R5 status with top", rd16(b+2), exp_sw());
    chk(rd16(b+6) == ip_off_in[15:0] && rd16(b+10) == op_off_in[15:0], "R1 offsets",
        {rd16(b+6), rd16(b+10)}, {ip_off_in[15:0], op_off_in[15:0]});
    chk(rd16(b+8) == 16'hEEEE && rd16(b+12) == 16'hEEEE, "R1 segment slots skipped",
        {rd16(b+8), rd16(b+12)}, 32'hEEEEEEEE);
    chk(upd_cnt == 0, "R12 no update on store", upd_cnt, 0);
    @(negedge clk);
    chk(done == 0 && busy == 0, "R10 done single pulse", {done, busy}, 0);
  endtask

  task automatic t_store_16prot();
    int b; b = 'h40;
    fill(); beats = 0; lat = 2; hold_err = 0;
    go(2'd0, 1'b0, 1'b1);
    wait_done();
    chk(beats == 7, "R2 beat count", beats, 7);
    chk(rd16(b+8) == ip_seg_in && rd16(b+12) == op_seg_in, "R2 segments",
        {rd16(b+8), rd16(b+12)}, {ip_seg_in, op_seg_in});
    chk(rd16(b+10) == op_off_in[15:0], "R2 operand offset", rd16(b+10), op_off_in[15:0]);
    chk(hold_err == 0, "R9 beat held during wait", hold_err, 0);
  endtask

  task automatic t_store_32real();
    int b; b = 'h40;
    fill(); beats = 0; lat = 1;
    go(2'd0, 1'b1, 1'b0);
    wait_done();
    chk(beats == 6, "R3 beat count", beats, 6);
    chk(rd16(b) == cw_in && rd16(b+4) == exp_sw() && rd16(b+8) == tw_in, "R3 words",
        {rd16(b), rd16(b+4), rd16(b+8)}, {cw_in, exp_sw(), tw_in});
    chk(rd16(b+12) == ip_off_in[15:0] && rd16(b+14) == 16'hEEEE, "R3 ip offset half",
        {rd16(b+12), rd16(b+14)}, {ip_off_in[15:0], 16'hEEEE});
    chk(rd16(b+20) == op_off_in[15:0] && rd16(b+16) == 16'hEEEE, "R3 op offset half",
        {rd16(b+20), rd16(b+16)}, {op_off_in[15:0], 16'hEEEE});
    chk(rd32(b+24) == ({16'h0, op_off_in[31:16]} << 12), "R3 shifted high part",
        rd32(b+24), {16'h0, op_off_in[31:16]} << 12);
  endtask

  task automatic t_store_32prot();
    int b; b = 'h40;
    fill(); beats = 0; lat = 0;
    top_in = 3'd7; sw_in = 16'h0005;
    go(2'd0, 1'b1, 1'b1);
    wait_done();
    chk(beats == 7, "R4 beat count", beats, 7);
    chk(rd32(b+12) == ip_off_in && rd32(b+16) == {16'h0, ip_seg_in}, "R4 ip pointer",
        {rd32(b+12), rd32(b+16)}, {ip_off_in, 16'h0, ip_seg_in});
    chk(rd32(b+20) == op_off_in && rd32(b+24) == {16'h0, op_seg_in}, "R4 op pointer",
        {rd32(b+20), rd32(b+24)}, {op_off_in, 16'h0, op_seg_in});
    chk(rd16(b+4) == 16'h3805, "R5 top 7 inserted", rd16(b+4), 16'h3805);
    top_in = 3'd2; sw_in = 16'h38C1;
  endtask

  task automatic t_full(input logic s32, input logic pm, input int nenv, input string tag);
    int b, len, u0c; b = 'h40; len = s32 ? 28 : 14;
    fill(); beats = 0; writes = 0; lat = 1; u0c = upd_cnt;
    go(2'd1, s32, pm);
    wait_done();
    chk(beats == nenv + 24 && writes == beats, {tag, " R6 beat count"}, beats, nenv + 24);
    for (int k = 0; k < 8; k++) begin
      logic [79:0] got;
      got = {rd16(b+len+10*k+8), rd32(b+len+10*k+4), rd32(b+len+10*k)};
      chk(got == regval(k), {tag, " R6 register image"}, got, regval(k));
    end
    chk(mem[b+len+80] == 8'hEE, {tag, " R6 nothing past end"}, mem[b+len+80], 8'hEE);
    chk(upd_cnt == u0c + 1 && cap_cw == 16'h037F && cap_sw == 0 && cap_tw == 16'hFFFF &&
        cap_top == 0, {tag, " R7 reinit values"}, {cap_cw, cap_sw, cap_tw, 5'd0, cap_top},
        {16'h037F, 16'h0, 16'hFFFF, 8'h0});
  endtask

  task automatic t_load(input logic s32, input string tag);
    int b, st, u0c; b = 'h40; st = s32 ? 4 : 2;
    fill(); beats = 0; writes = 0; lat = 1; u0c = upd_cnt;
    mem[b] = 8'h3F; mem[b+1] = 8'h0C;
    mem[b+st] = 8'h05; mem[b+st+1] = 8'h2A;
    mem[b+2*st] = 8'h0F; mem[b+2*st+1] = 8'h0F;
    if (s32) begin mem[b+2] = 8'h11; mem[b+3] = 8'h11; end
    go(2'd2, s32, 1'b1);
    wait_done();
    chk(beats == 3 && writes == 0, {tag, " R8 three reads"}, {beats, writes}, {32'd3, 32'd0});
    chk(upd_cnt == u0c + 1 && cap_cw == 16'h0C3F && cap_sw == 16'h2A05 && cap_tw == 16'h0F0F,
        {tag, " R8 loaded words"}, {cap_cw, cap_sw, cap_tw}, {16'h0C3F, 16'h2A05, 16'h0F0F});
    chk(cap_top == 3'd5, {tag, " R8 top from status"}, cap_top, 3'd5);
  endtask

  task automatic t_ignore();
    int u0c;
    fill(); beats = 0; writes = 0; lat = 2; u0c = upd_cnt;
    go(2'd1, 1'b0, 1'b0);
    for (int i = 0; i < 40; i++) @(negedge clk);
    cmd = 2'd2; size32 = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    chk(beats == 29 && writes == 29, "R11 start while busy ignored", beats, 29);
    chk(upd_cnt == u0c + 1 && cap_cw == 16'h037F, "R11 single full-save update",
        {upd_cnt, cap_cw}, {u0c + 1, 16'h037F});
    beats = 0;
    go(2'd3, 1'b0, 1'b0);
    for (int i = 0; i < 6; i++) @(negedge clk);
    chk(beats == 0 && busy == 0, "R11 cmd 3 ignored", {beats, busy}, 0);
  endtask

  initial begin
    #2_000_000;
    chk(1'b0, "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfails);
    $finish;
  end

  initial begin
    fill();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_store_16real();
    t_store_16prot();
    t_store_32real();
    t_store_32prot();
    t_full(1'b0, 1'b0, 5, "16r");
    t_full(1'b1, 1'b1, 7, "32p");
    t_load(1'b0, "16");
    t_load(1'b1, "32");
    t_ignore();
    $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfails);
    $finish;
  end
endmodule